// File: doc/BRIEF.md
# Register-Pointer Serial Slave with Power-Fail Lockout

This block is a two-wire serial bus slave that runs entirely in the system clock domain. It synchronizes the serial clock and data lines, finds START, repeated START and STOP conditions, and serves a small register space of six byte locations. Locations 0 to 3 hold the four bytes of a seconds count, least significant first. Location 4 is a control byte and location 5 is a charger configuration byte. The surrounding logic sees every location on a flat output bus.

A master addresses the slave with the 7-bit address 1101000. After a write address, the first byte sets an internal register pointer and each further byte is stored at that pointer. After a read address, bytes are returned starting at the pointer. The pointer advances after every byte and wraps from the last location back to 0. It survives STOP and repeated START, so a later read resumes where the last access left off. While the power-fail input is high the slave ignores the bus and releases the data line. The data line is driven as an open-drain enable and is never actively driven high.

Top module: `i2c_regslave`

## Requirements
- R1: Only the address byte 1101000 followed by the direction bit (D0h = write, D1h = read) is acknowledged. Any other address gets no acknowledge, and the slave ignores all following bytes until the next START.
- R2: In a write, the first byte after the address loads the pointer. Values 0 to 5 are taken as they are and any larger value loads 0. Each later byte is stored at the pointer, and the pointer then advances by one.
- R3: For both reads and writes, the pointer moves from location 5 to location 0.
- R4: In a read, bytes are sent MSB first, starting at the pointer, and the pointer advances after each byte. The byte is captured on the SCL falling edge that ends the preceding acknowledge bit.
- R5: The pointer is kept across transactions. A read that is not preceded by a pointer write starts where the previous access stopped.
- R6: A repeated START returns the slave to address matching without a STOP and leaves the pointer unchanged.
- R7: A master not-acknowledge ends a read. The slave then releases SDA (sda_oe_o = 0) and stays idle until the next START.
- R8: The slave acknowledges the matching address, the pointer byte and every written data byte by pulling SDA low during the ninth clock.
- R9: While pwr_fail_i is high, no byte is acknowledged and no location changes. sda_oe_o goes low on the clock edge that follows.
- R10: When power is good, sda_oe_o changes only while SCL is low.
- R11: After reset, sda_oe_o is 0 and every location in regs_o is 0.
- R12: A STOP returns the slave to idle. Bytes clocked after a STOP without a new START get no acknowledge and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND result) |
| pwr_fail_i | input | 1 | High while supply is below the power-fail threshold |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | 48 | Register space, location i at bits [8i+7:8i] |

## Verification
The bench builds the block with its default parameters: six locations, address 68h and two synchronizer stages. This keeps every pointer value, every wrap point and every byte-count class within a short sweep. Writes are swept over every start pointer with burst lengths 1, 3 and 7, so every location is written and the 5-to-0 wrap is crossed at each offset. Reads are swept over every start pointer, both after a pointer write and after a repeated START, and include reads with no pointer write before them. Expected bytes come from a location model in the bench that is filled with arithmetic patterns.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } fsm_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } phase_e;

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p_q, scl_p_d;
    logic sda_p_q, sda_p_d;

    always_comb begin
        scl_p_d = scl_s_i;
        sda_p_d = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end

    assign scl_rise_o = scl_s_i & ~scl_p_q;
    assign scl_fall_o = ~scl_s_i & scl_p_q;
    assign start_o    = scl_s_i & scl_p_q & sda_p_q & ~sda_s_i;
    assign stop_o     = scl_s_i & scl_p_q & ~sda_p_q & sda_s_i;
endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
    parameter int NREG = 6,
    parameter int PW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PW-1:0]     waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [PW-1:0]     raddr_i,
    output logic [7:0]        rdata_o,
    output logic [NREG*8-1:0] regs_o
);
    logic [7:0] mem_q [NREG];
    logic [7:0] mem_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_loc
        always_comb begin
            mem_d[g] = (we_i && waddr_i == PW'(g)) ? wdata_i : mem_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end

        assign regs_o[g*8 +: 8] = mem_q[g];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr_i == PW'(i)) rdata_o = mem_q[i];
        end
    end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
    parameter logic [6:0] SLV_ADDR    = 7'h68,
    parameter int         NREG        = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pwr_fail_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o
);
    import i2c_rs_pkg::*;

    localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        fsm_e          state;
        phase_e        phase;
        logic [3:0]    bitcnt;
        logic [7:0]    shreg;
        logic          rw;
        logic          mack;
        logic [PW-1:0] ptr;
        logic          sda_oe;
    } slv_st_t;

    slv_st_t st_q, st_d;

    logic [1:0]    sync_w;
    logic          scl_s, sda_s;
    logic          ev_rise, ev_fall, ev_start, ev_stop;
    logic          wr_en;
    logic [7:0]    rd_data;
    logic [PW-1:0] ptr_w;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_load(input logic [7:0] b);
        return (int'(b) < NREG) ? b[PW-1:0] : '0;
    endfunction

    i2c_rs_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (sync_w)
    );
    assign scl_s = sync_w[1];
    assign sda_s = sync_w[0];

    i2c_rs_cond cond_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_o (ev_rise),
        .scl_fall_o (ev_fall),
        .start_o    (ev_start),
        .stop_o     (ev_stop)
    );

    i2c_rs_regs #(.NREG(NREG), .PW(PW)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (st_q.ptr),
        .wdata_i (st_q.shreg),
        .raddr_i (st_q.ptr),
        .rdata_o (rd_data),
        .regs_o  (regs_o)
    );

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (pwr_fail_i) begin
            st_d.state  = ST_IDLE;
            st_d.sda_oe = 1'b0;
        end else if (ev_start) begin
            st_d.state  = ST_RX;
            st_d.phase  = PH_ADDR;
            st_d.bitcnt = '0;
            st_d.sda_oe = 1'b0;
        end else if (ev_stop) begin
            st_d.state  = ST_IDLE;
            st_d.sda_oe = 1'b0;
        end else begin
            unique case (st_q.state)
                ST_RX: begin
                    if (ev_rise) begin
                        st_d.shreg  = {st_q.shreg[6:0], sda_s};
                        st_d.bitcnt = st_q.bitcnt + 4'd1;
                    end else if (ev_fall && st_q.bitcnt == 4'd8) begin
                        st_d.bitcnt = '0;
                        unique case (st_q.phase)
                            PH_ADDR: begin
                                if (st_q.shreg[7:1] == SLV_ADDR) begin
                                    st_d.rw     = st_q.shreg[0];
                                    st_d.sda_oe = 1'b1;
                                    st_d.state  = ST_ACK;
                                end else begin
                                    st_d.state  = ST_IDLE;
                                end
                            end
                            PH_PTR: begin
                                st_d.ptr    = ptr_load(st_q.shreg);
                                st_d.sda_oe = 1'b1;
                                st_d.state  = ST_ACK;
                            end
                            default: begin
                                wr_en       = 1'b1;
                                st_d.ptr    = ptr_next(st_q.ptr);
                                st_d.sda_oe = 1'b1;
                                st_d.state  = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev_fall) begin
                        st_d.bitcnt = '0;
                        if (st_q.phase == PH_ADDR && st_q.rw) begin
                            st_d.shreg  = rd_data;
                            st_d.ptr    = ptr_next(st_q.ptr);
                            st_d.sda_oe = ~rd_data[7];
                            st_d.state  = ST_TX;
                        end else begin
                            st_d.sda_oe = 1'b0;
                            st_d.state  = ST_RX;
                            st_d.phase  = (st_q.phase == PH_ADDR) ? PH_PTR : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (ev_fall) begin
                        if (st_q.bitcnt == 4'd7) begin
                            st_d.sda_oe = 1'b0;
                            st_d.state  = ST_MACK;
                        end else begin
                            st_d.shreg  = {st_q.shreg[6:0], 1'b0};
                            st_d.sda_oe = ~st_q.shreg[6];
                            st_d.bitcnt = st_q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_rise) begin
                        st_d.mack = ~sda_s;
                    end else if (ev_fall) begin
                        if (st_q.mack) begin
                            st_d.shreg  = rd_data;
                            st_d.ptr    = ptr_next(st_q.ptr);
                            st_d.sda_oe = ~rd_data[7];
                            st_d.bitcnt = '0;
                            st_d.state  = ST_TX;
                        end else begin
                            st_d.state  = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, phase: PH_ADDR, bitcnt: '0, shreg: '0,
                      rw: 1'b0, mack: 1'b0, ptr: '0, sda_oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.sda_oe;
    assign ptr_w    = st_q.ptr;
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
    parameter int NREG = 6,
    parameter int PW   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              pwr_fail_i,
    input logic              sda_oe_o,
    input logic [NREG*8-1:0] regs_o,
    input logic [PW-1:0]     ptr_i
);
    logic [NREG-1:0] loc_chg;
    logic [NREG*8-1:0] regs_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_p <= '0;
        else        regs_p <= regs_o;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_chg
        assign loc_chg[g] = (regs_o[g*8 +: 8] != regs_p[g*8 +: 8]);
    end

    // R9
    pf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> !sda_oe_o);

    // R9
    pf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> $stable(regs_o));

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_fail_i && !$past(pwr_fail_i) && $changed(sda_oe_o)) |-> !scl_i);

    // R2
    one_loc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loc_chg));

    // R3
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_i) < NREG);
endmodule

bind i2c_regslave i2c_regslave_chk #(.NREG(NREG), .PW(PW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .pwr_fail_i (pwr_fail_i),
    .sda_oe_o   (sda_oe_o),
    .regs_o     (regs_o),
    .ptr_i      (ptr_w)
);

// File: tb/i2c_regslave_tb_top.sv
`timescale 1ns/1ps
module i2c_regslave_tb_top;
    localparam int NREG = 6;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic bus_sda;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [7:0] mdl [NREG];
    int mptr = 0;

    always #2.5 clk = ~clk;

    assign bus_sda = m_sda & ~sda_oe;

    i2c_regslave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (bus_sda),
        .pwr_fail_i (pwr_fail),
        .sda_oe_o   (sda_oe),
        .regs_o     (regs)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nxt(input int p);
        return (p == NREG - 1) ? 0 : p + 1;
    endfunction

    function automatic logic [NREG*8-1:0] mdl_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ack = (bus_sda == 1'b0);
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            m_scl = 1'b1; wq(Q);
            b[i] = bus_sda;
            wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    // write burst: pointer p, n data bytes
    task automatic wr_txn(input int p, input int n, input int base);
        bit ack;
        logic [7:0] d;
        bus_start();
        wr_byte(8'hD0, ack);
        chk(ack, "R1 write address ack", ack, 1);
        wr_byte(8'(p), ack);
        chk(ack, "R8 pointer ack", ack, 1);
        mptr = (p < NREG) ? p : 0;
        for (int k = 0; k < n; k++) begin
            d = 8'((base * 37 + k * 11 + p * 5 + 3) & 255);
            wr_byte(d, ack);
            chk(ack, "R8 data ack", ack, 1);
            mdl[mptr] = d;
            mptr = nxt(mptr);
        end
        bus_stop();
        chk(regs == mdl_flat(), "R2 R3 write burst contents", regs, mdl_flat());
    endtask

    // read burst of n bytes from current pointer
    task automatic rd_burst(input int n, input string tag);
        bit ack;
        logic [7:0] b;
        wr_byte(8'hD1, ack);
        chk(ack, "R1 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, b);
            chk(b == mdl[mptr], tag, b, mdl[mptr]);
            mptr = nxt(mptr);
        end
        chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic set_ptr(input int p);
        bit ack;
        bus_start();
        wr_byte(8'hD0, ack);
        wr_byte(8'(p), ack);
        chk(ack, "R8 pointer ack", ack, 1);
        mptr = p;
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R11 reset state
        chk(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
        chk(regs == '0, "R11 reset registers", regs, 0);

        // R2 R3 write sweep over every start pointer and several burst lengths
        for (int p = 0; p < NREG; p++) begin
            wr_txn(p, 1, p);
            wr_txn(p, 3, p + 10);
            wr_txn(p, 7, p + 20);
        end

        // R2 out-of-range pointer loads location 0
        wr_txn(9, 2, 77);
        chk(mptr == 2, "R2 oversize pointer", mptr, 2);

        // R4 R3 read sweep with pointer write and STOP before the read
        for (int p = 0; p < NREG; p++) begin
            set_ptr(p);
            bus_stop();
            bus_start();
            rd_burst(7, "R4 R3 read byte");
        end

        // R6 repeated START between pointer write and read
        for (int p = 0; p < NREG; p++) begin
            set_ptr(p);
            bus_rstart();
            rd_burst(2, "R6 read after repeated start");
        end

        // R5 reads without pointer write resume from stored pointer
        bus_start();
        rd_burst(3, "R5 resume read");
        bus_start();
        rd_burst(4, "R5 second resume read");

        // R1 wrong addresses: no ack, following bytes ignored
        bus_start();
        wr_byte(8'hD2, ack);
        chk(!ack, "R1 wrong address nack", ack, 0);
        wr_byte(8'h01, ack);
        chk(!ack, "R1 ignored after wrong address", ack, 0);
        wr_byte(8'h5A, ack);
        chk(!ack, "R1 ignored data", ack, 0);
        bus_stop();
        chk(regs == mdl_flat(), "R1 registers unchanged", regs, mdl_flat());
        bus_start();
        wr_byte(8'hA0, ack);
        chk(!ack, "R1 other address nack", ack, 0);
        bus_stop();

        // R12 bytes after STOP without START
        set_ptr(4);
        bus_stop();
        m_sda = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
        wr_byte(8'hC3, ack);
        chk(!ack, "R12 no ack after stop", ack, 0);
        m_scl = 1'b1; wq(2*Q);
        chk(regs == mdl_flat(), "R12 registers unchanged", regs, mdl_flat());

        // R7 nack ends read: further clocks read released line
        bus_start();
        rd_burst(1, "R7 single read");
        m_scl = 1'b0; wq(Q);
        rd_byte(1'b1, b);
        chk(b == 8'hFF, "R7 idle after nack", b, 8'hFF);
        m_scl = 1'b1; wq(2*Q);

        // R9 power fail before transaction
        pwr_fail = 1'b1;
        wq(2);
        chk(sda_oe == 1'b0, "R9 released under power fail", sda_oe, 0);
        bus_start();
        wr_byte(8'hD0, ack);
        chk(!ack, "R9 no address ack", ack, 0);
        wr_byte(8'h00, ack);
        wr_byte(8'hEE, ack);
        chk(!ack, "R9 no data ack", ack, 0);
        bus_stop();
        chk(regs == mdl_flat(), "R9 registers unchanged", regs, mdl_flat());
        pwr_fail = 1'b0;
        wq(4);

        // R9 power fail raised inside a write
        set_ptr(1);
        pwr_fail = 1'b1;
        wr_byte(8'h99, ack);
        chk(!ack, "R9 mid-write nack", ack, 0);
        bus_stop();
        pwr_fail = 1'b0;
        wq(4);
        chk(regs == mdl_flat(), "R9 mid-write unchanged", regs, mdl_flat());

        // R8 normal access after recovery
        wr_txn(5, 2, 91);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule